// File: doc/BRIEF.md
# DDR Input Capture and Resynchronization Cell

This block is the receive-side capture cell for a data pin. In single-data-rate mode, the pin is registered once on each rising edge of the system clock. In double-data-rate mode, the pin is sampled on both edges of a source strobe. This produces a rising-edge stream and a falling-edge stream, and both are moved into the system clock domain before they reach the core. The synchronization step can run on the true system clock edge or on the inverted edge. The second choice gives extra margin when the strobe phase sits close to the rising system clock edge. The pin first passes through an input path chosen at build time: either a direct path or a fixed hold-fixing delay. In this model both paths pass the data through unchanged.

A small controller holds one of three states, and the output register acts on that state. ST_RST is entered on any rising clock edge with reset high. On an enabled edge, the controller moves to ST_SDR when the mode input is 0 or to ST_DDR when it is 1. The transitions are ST_RST→ST_SDR, ST_RST→ST_DDR, ST_SDR→ST_DDR, ST_DDR→ST_SDR, and any state→ST_RST. When the clock enable is low, the state does not change. Because the output register acts on the state the controller already holds, a change of the mode input reaches the outputs one enabled edge later.

Top module: `ddr_in_capture`

## Requirements
- R1: A rising system clock edge with `rst` high clears `q_rise` and `q_fall` to zero, regardless of `ce`.
- R2: On the first enabled rising edge after reset is released, the outputs load zero, because the controller is still in ST_RST.
- R3: In ST_SDR, an enabled rising edge loads `q_rise` with the pin value at that edge and loads `q_fall` with zero.
- R4: In ST_DDR with `clk_inv`=0, an enabled rising edge loads `q_rise` with the latest rising-strobe sample and `q_fall` with the latest falling-strobe sample.
- R5: In ST_DDR with `clk_inv`=1, the two strobe samples are first taken on the falling system clock edge. The next enabled rising edge then loads those values onto `q_rise` and `q_fall`, so each pair still appears one system clock cycle after the pair is captured.
- R6: While `ce` is low, `q_rise`, `q_fall` and the controller state keep their values.
- R7: While `ce` is low, the falling-edge synchronization registers also hold. With `clk_inv`=1, the first enabled edge after `ce` returns therefore delivers the pair captured before the hold began.
- R8: The mode input (0 selects single data rate, 1 selects double data rate) is adopted into the state on an enabled rising edge. It affects the outputs from the next enabled edge onward.
- R9: The strobe-edge capture registers keep sampling while `ce` is low. With `clk_inv`=0, the first enabled edge after `ce` returns delivers the newest pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for synchronization, output and state registers |
| mode_ddr | input | 1 | 0 = single data rate, 1 = double data rate |
| clk_inv | input | 1 | 0 = synchronize on the rising system edge, 1 = synchronize on the falling edge |
| strobe | input | 1 | Source-synchronous strobe |
| pin | input | DW | Data pin(s) |
| q_rise | output | DW | Rising-edge (or single-rate) data toward the core |
| q_fall | output | DW | Falling-edge data toward the core (zero in single-rate mode) |

## Verification
The hardest case to reach is the inverted-polarity path with the clock enable dropping across a falling system clock edge. In that case the falling-edge synchronization registers keep a stale pair while the strobe registers move on. The bench drives a strobe that is phase-locked to the clock, with a separate offset for each polarity, so that every rising-strobe and falling-strobe sample lands in a known slot. It then mixes random clock-enable drops, mode toggles and occasional resets into long random data runs. A bench-side model of each requirement predicts which pair, stale or fresh, must appear at each edge.

// File: rtl/ddr_in_pkg.sv
`timescale 1ns/1ps
package ddr_in_pkg;
    typedef enum logic [1:0] {
        ST_RST = 2'd0,
        ST_SDR = 2'd1,
        ST_DDR = 2'd2
    } cap_state_t;
endpackage

// File: rtl/ddr_in_path.sv
`timescale 1ns/1ps
// Input path ahead of the capture registers: direct, or the hold-fixing
// fixed delay (modelled as a transparent stage).
module ddr_in_path #(
    parameter int DW          = 1,
    parameter bit FIXED_DELAY = 1'b0
) (
    input  logic [DW-1:0] pin_raw,
    output logic [DW-1:0] pin_dly
);
    generate
        if (FIXED_DELAY) begin : g_delay
            logic [DW-1:0] dly_stage;
            assign dly_stage = pin_raw;
            assign pin_dly   = dly_stage;
        end else begin : g_direct
            assign pin_dly = pin_raw;
        end
    endgenerate
endmodule

// File: rtl/ddr_in_strobe_cap.sv
`timescale 1ns/1ps
// Dual-edge capture in the strobe domain. No reset or enable: it always samples.
module ddr_in_strobe_cap #(
    parameter int DW = 1
) (
    input  logic          strobe,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] cap_rise,
    output logic [DW-1:0] cap_fall
);
    always_ff @(posedge strobe) begin
        cap_rise <= din;
    end

    always_ff @(negedge strobe) begin
        cap_fall <= din;
    end
endmodule

// File: rtl/ddr_in_resync_neg.sv
`timescale 1ns/1ps
// Falling-system-edge synchronization registers used by the inverted polarity.
module ddr_in_resync_neg #(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic [DW-1:0] cap_rise,
    input  logic [DW-1:0] cap_fall,
    output logic [DW-1:0] sn_rise,
    output logic [DW-1:0] sn_fall
);
    always_ff @(negedge clk) begin
        if (rst) begin
            sn_rise <= '0;
            sn_fall <= '0;
        end else if (ce) begin
            sn_rise <= cap_rise;
            sn_fall <= cap_fall;
        end
    end

    // R7
    sn_hold_chk: assert property (@(negedge clk) disable iff (rst)
        !ce |=> ($stable(sn_rise) && $stable(sn_fall)));
endmodule

// File: rtl/ddr_in_fsm.sv
`timescale 1ns/1ps
module ddr_in_fsm
    import ddr_in_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       mode_ddr,
    output cap_state_t state
);
    cap_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        if (ce) begin
            state_nxt = mode_ddr ? ST_DDR : ST_SDR;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_RST;
        end else begin
            state <= state_nxt;
        end
    end

    // R8
    mode_adopt_chk: assert property (@(posedge clk) disable iff (rst)
        ce |=> (state == ($past(mode_ddr) ? ST_DDR : ST_SDR)));
    // R6
    state_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(state));
endmodule

// File: rtl/ddr_in_outreg.sv
`timescale 1ns/1ps
module ddr_in_outreg
    import ddr_in_pkg::*;
#(
    parameter int DW = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          clk_inv,
    input  cap_state_t    state,
    input  logic [DW-1:0] pin_d,
    input  logic [DW-1:0] cap_rise,
    input  logic [DW-1:0] cap_fall,
    input  logic [DW-1:0] sn_rise,
    input  logic [DW-1:0] sn_fall,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall
);
    localparam int PAIR_W = 2 * DW;

    logic [PAIR_W-1:0] pair_sel;

    assign pair_sel = clk_inv ? {sn_rise, sn_fall} : {cap_rise, cap_fall};

    always_ff @(posedge clk) begin
        if (rst) begin
            q_rise <= '0;
            q_fall <= '0;
        end else if (ce) begin
            unique case (state)
                ST_RST: begin
                    q_rise <= '0;
                    q_fall <= '0;
                end
                ST_SDR: begin
                    q_rise <= pin_d;
                    q_fall <= '0;
                end
                ST_DDR: begin
                    {q_rise, q_fall} <= pair_sel;
                end
                default: begin
                    q_rise <= '0;
                    q_fall <= '0;
                end
            endcase
        end
    end

    // R1 R2
    post_rst_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q_rise == '0 && q_fall == '0));
    // R3
    sdr_load_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && state == ST_SDR) |=> (q_rise == $past(pin_d) && q_fall == '0));
    // R4
    ddr_true_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && state == ST_DDR && !clk_inv) |=>
            (q_rise == $past(cap_rise) && q_fall == $past(cap_fall)));
    // R5
    ddr_inv_chk: assert property (@(posedge clk) disable iff (rst)
        (ce && state == ST_DDR && clk_inv) |=>
            (q_rise == $past(sn_rise) && q_fall == $past(sn_fall)));
    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(q_rise) && $stable(q_fall)));
endmodule

// File: rtl/ddr_in_capture.sv
`timescale 1ns/1ps
module ddr_in_capture
    import ddr_in_pkg::*;
#(
    parameter int DW          = 1,
    parameter bit FIXED_DELAY = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          mode_ddr,
    input  logic          clk_inv,
    input  logic          strobe,
    input  logic [DW-1:0] pin,
    output logic [DW-1:0] q_rise,
    output logic [DW-1:0] q_fall
);
    logic [DW-1:0] pin_d;
    logic [DW-1:0] cap_rise;
    logic [DW-1:0] cap_fall;
    logic [DW-1:0] sn_rise;
    logic [DW-1:0] sn_fall;
    cap_state_t    state;

    ddr_in_path #(.DW(DW), .FIXED_DELAY(FIXED_DELAY)) u_path (
        .pin_raw (pin),
        .pin_dly (pin_d)
    );

    ddr_in_strobe_cap #(.DW(DW)) u_cap (
        .strobe   (strobe),
        .din      (pin_d),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall)
    );

    ddr_in_resync_neg #(.DW(DW)) u_sync_n (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .sn_rise  (sn_rise),
        .sn_fall  (sn_fall)
    );

    ddr_in_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .mode_ddr (mode_ddr),
        .state    (state)
    );

    ddr_in_outreg #(.DW(DW)) u_out (
        .clk      (clk),
        .rst      (rst),
        .ce       (ce),
        .clk_inv  (clk_inv),
        .state    (state),
        .pin_d    (pin_d),
        .cap_rise (cap_rise),
        .cap_fall (cap_fall),
        .sn_rise  (sn_rise),
        .sn_fall  (sn_fall),
        .q_rise   (q_rise),
        .q_fall   (q_fall)
    );
endmodule

// File: tb/ddr_in_capture_tb.sv
`timescale 1ns/1ps
module ddr_in_capture_tb;
    localparam int DW = 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ce = 1'b1;
    logic          mode_ddr = 1'b0;
    logic          clk_inv = 1'b0;
    logic          strobe = 1'b0;
    logic [DW-1:0] pin = '0;
    logic [DW-1:0] q_rise;
    logic [DW-1:0] q_fall;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    int            st = 0;        // 0 reset, 1 single rate, 2 double rate
    int            last_used = 0;
    logic [DW-1:0] pa = '0, pb = '0;
    logic [DW-1:0] snr = '0, snf = '0;
    logic [DW-1:0] er = '0, ef = '0;
    logic          prev_ce = 1'b1;
    int            skip = 0;

    always #5 clk = ~clk;

    ddr_in_capture #(.DW(DW)) u_dut (
        .clk(clk), .rst(rst), .ce(ce), .mode_ddr(mode_ddr), .clk_inv(clk_inv),
        .strobe(strobe), .pin(pin), .q_rise(q_rise), .q_fall(q_fall)
    );

    function automatic logic [2*DW-1:0] exp_pair(input int s, input logic inv,
                                                 input logic [DW-1:0] dinp);
        if (s == 1) return {dinp, {DW{1'b0}}};
        if (s == 2) return inv ? {snr, snf} : {pa, pb};
        return '0;
    endfunction

    task automatic check(input string tag, input logic [DW-1:0] exr, input logic [DW-1:0] exf);
        checks++;
        if (q_rise !== exr || q_fall !== exf) begin
            fails++;
            $display("FAIL %s: q_rise=%h q_fall=%h expected %h %h at %0t",
                     tag, q_rise, q_fall, exr, exf, $time);
        end
    endtask

    // One system clock period, starting at a falling clock edge.
    task automatic cycle(input logic n_rst, input logic n_ce, input logic n_mode, input logic n_inv);
        logic [DW-1:0] a, b, dinp;
        logic [2*DW-1:0] ep;
        int st_used;
        string tag;
        a = DW'($urandom);
        b = DW'($urandom);
        // model of the falling-edge sync at the start of the period
        if (rst) begin snr = '0; snf = '0; end
        else if (ce) begin snr = pa; snf = pb; end
        if (n_inv) begin
            #0.5 pin = a;
            #0.5 rst = n_rst; ce = n_ce; mode_ddr = n_mode; clk_inv = n_inv;
            #1   strobe = 1'b1;
            #2.5 pin = b;
            dinp = b;
        end else begin
            #1 pin = pb; rst = n_rst; ce = n_ce; mode_ddr = n_mode; clk_inv = n_inv;
            #2 strobe = 1'b0;
            dinp = pb;
        end
        // model of the rising edge
        st_used = st;
        if (n_rst) begin
            er = '0; ef = '0; st = 0;
        end else if (n_ce) begin
            ep = exp_pair(st, n_inv, dinp);
            {er, ef} = ep;
            st = n_mode ? 2 : 1;
        end
        if (n_rst) tag = "R1";
        else if (!n_ce) tag = "R6";
        else if (st_used == 0) tag = "R2";
        else if (st_used != last_used && last_used != 0) tag = "R8";
        else if (st_used == 1) tag = "R3";
        else if (n_inv) tag = !prev_ce ? "R7" : "R5";
        else tag = !prev_ce ? "R9" : "R4";
        if (!n_rst && n_ce) last_used = st_used;
        if (n_rst) last_used = 0;
        if (n_inv) begin
            #2.5;
            if (n_rst || skip == 0) check(tag, er, ef);
            strobe = 1'b0;
            #3;
        end else begin
            #3 pin = a;
            #1;
            if (n_rst || skip == 0) check(tag, er, ef);
            #1 strobe = 1'b1;
            #2;
        end
        if (!n_rst && skip > 0) skip--;
        prev_ce = n_ce;
        pa = a;
        pb = b;
    endtask

    task automatic run_random(input int n, input logic inv);
        logic m;
        m = 1'b1;
        for (int i = 0; i < n; i++) begin
            logic r, c;
            r = ($urandom % 60) == 0;
            c = ($urandom % 6) != 0;
            if (($urandom % 10) == 0) m = ~m;
            cycle(r, c, m, inv);
        end
    endtask

    initial begin
        void'($urandom(32'd5150));
        // reset, true polarity, single rate first
        skip = 4;
        cycle(1, 1, 0, 0);
        cycle(1, 0, 0, 0);          // R1 with ce low
        cycle(0, 1, 0, 0);          // R2 first edge after release
        for (int i = 0; i < 6; i++) cycle(0, 1, 0, 0);   // R3
        cycle(0, 1, 1, 0);          // R8 switch
        for (int i = 0; i < 6; i++) cycle(0, 1, 1, 0);   // R4
        cycle(0, 0, 1, 0);          // R6
        cycle(0, 1, 1, 0);          // R9
        cycle(0, 1, 1, 0);
        run_random(300, 0);
        // switch polarity under reset
        skip = 4;
        cycle(1, 1, 1, 1);
        cycle(1, 1, 1, 1);
        for (int i = 0; i < 8; i++) cycle(0, 1, 1, 1);   // R5
        cycle(0, 0, 1, 1);          // R6
        cycle(0, 1, 1, 1);          // R7
        cycle(0, 1, 1, 1);
        cycle(0, 1, 0, 1);          // R8
        cycle(0, 1, 0, 1);
        run_random(300, 1);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule